// File: doc/BRIEF.md
# CPU Core Power Sequencer

This block switches the power of individual CPU cores in a multi-cluster system on and off. A requester sends a command on a valid/ready port. The command carries an operation, a cluster index, a core index and the requester's own core ID. For every core the block owns an 8-bit power-switch enable, an output clamp, an active-low power-on reset, an active-low core reset, a 64-bit boot-mode bit and a debug power-up flag. The block changes these signals one step at a time, in a fixed order. Consecutive steps are separated by a programmable gap.

Power-up closes the switches gradually, in stages, and then waits a settle time before the clamp is released. Power-down opens all switches in one write, and only after the core is clamped and held in reset. Core 0 is never clamped. A bulk operation powers off every core except the requester, walking the cores in ascending ID order. Busy, ready and a one-cycle done pulse tell the requester where the command stands.

Top module: `cpu_core_pwr_seq`

## Requirements
- R1: When reset is released, every core other than the boot core has switch 0xFF, clamp 1 (engaged), por_rst_n 0, core_rst_n 0, boot64 0 and dbg_pwrup 0. Core 0's clamp is 0 even while that core is off. The boot core starts at switch 0x00, clamp 0, both resets 1, boot64 1 and dbg_pwrup 1.
- R2: cmd_ready equals the inverse of busy. A command is taken on the clock edge where cmd_valid and cmd_ready are both 1. A command held valid while busy is 1 is ignored. done is a one-cycle pulse on the edge where the final step lands, and busy falls on that same edge.
- R3: With D equal to step_delay (a value of 0 counts as 1), the first step lands D cycles after the accepting edge. Each later step lands D cycles after the one before it.
- R4: Power-on (cmd_op 2'b01) applies these steps in order: core_rst_n to 0, por_rst_n to 0, boot64 to 1, the switch ramp, clamp to 0, por_rst_n to 1, core_rst_n to 1, and dbg_pwrup to 1 as the last step.
- R5: The ramp writes 0xFE, 0xF8, 0xE0, 0x80 and 0x00 in consecutive steps. The clamp release that follows 0x00 lands D plus SETTLE_CYC cycles after it.
- R6: If the switch already reads 0x00 when the ramp would start, the ramp and the settle time are skipped. The clamp release lands in the step where 0xFE would have been written.
- R7: Power-off (cmd_op 2'b10) applies these steps in order: dbg_pwrup to 0, clamp to 1, por_rst_n to 0, and switch to 0xFF as the last step.
- R8: The clamp of core 0 stays 0 at all times. Its clamp step in a power-off still uses one step slot but changes nothing.
- R9: Off-all-others (cmd_op 2'b11) runs the power-off sequence on each core whose ID differs from cmd_req_id, in ascending ID order, back to back with gap D. The requester's core is left untouched, and done pulses once, after the last core.
- R10: The core ID is {cmd_cluster, cmd_core}, and core i uses pwr_sw bits [8i+7:8i]. cmd_op 2'b00 is a no-op: it is accepted, pulses done on the accepting edge and changes no core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 00 no-op, 01 on, 10 off, 11 off all others |
| cmd_cluster | input | 1 | Target cluster index |
| cmd_core | input | 2 | Target core index within the cluster |
| cmd_req_id | input | 3 | Requester core ID, used by the off-all-others operation |
| step_delay | input | 8 | Gap between steps in cycles (0 treated as 1) |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| pwr_sw | output | 64 | Per-core switch enables, 0xFF off, 0x00 on |
| out_clamp | output | 8 | Per-core output clamp, 1 engaged |
| por_rst_n | output | 8 | Per-core power-on reset, 0 asserted |
| core_rst_n | output | 8 | Per-core core reset, 0 asserted |
| boot64 | output | 8 | Per-core 64-bit boot-mode bit |
| dbg_pwrup | output | 8 | Per-core debug power-up flag |

## Verification
Each step of a command lands at a known edge: accept edge + k·D, with SETTLE_CYC more for every step after the final ramp write. done is due on the edge of the last step and must be low again one edge later. When a command is issued, the driver computes every due edge from these rules and queues the expected core state for that edge. It also queues the unchanged state for the edge just before each step, so a step that lands one cycle early or late is caught. The monitor compares each queued item at the falling clock edge after its due rising edge, so every register on the way has settled.

// File: rtl/cps_pkg.sv
package cps_pkg;

   typedef enum logic [1:0] {
      OP_NOP        = 2'b00,
      OP_ON         = 2'b01,
      OP_OFF        = 2'b10,
      OP_OFF_OTHERS = 2'b11
   } cps_op_e;

   typedef enum logic [3:0] {
      ACT_CRST_ASSERT,
      ACT_CRST_RELEASE,
      ACT_POR_ASSERT,
      ACT_POR_RELEASE,
      ACT_BOOT64_SET,
      ACT_SW_WRITE,
      ACT_CLAMP_SET,
      ACT_CLAMP_RELEASE,
      ACT_DBG_SET,
      ACT_DBG_CLEAR
   } cps_act_e;

endpackage

// File: rtl/cps_step_timer.sv
module cps_step_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expire = (cnt_q == CNT_W'(1));

   // R3: a gap of zero would never expire
   p_load_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val != '0));

endmodule

// File: rtl/cps_core_bank.sv
module cps_core_bank
   import cps_pkg::*;
#(
   parameter int SW_W     = 8,
   parameter bit IS_BOOT  = 1'b0,
   parameter bit NO_CLAMP = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            act_en,
   input  cps_act_e        act_kind,
   input  logic [SW_W-1:0] act_sw,
   output logic [SW_W-1:0] sw,
   output logic            clamp,
   output logic            por_n,
   output logic            crst_n,
   output logic            boot64,
   output logic            dbg
);

   localparam logic [SW_W-1:0] SW_RST = IS_BOOT ? '0 : '1;
   localparam logic            LIVE   = IS_BOOT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw     <= SW_RST;
         por_n  <= LIVE;
         crst_n <= LIVE;
         boot64 <= LIVE;
         dbg    <= LIVE;
      end else if (act_en) begin
         case (act_kind)
            ACT_SW_WRITE:     if (act_sw != sw) sw <= act_sw;
            ACT_POR_ASSERT:   por_n  <= 1'b0;
            ACT_POR_RELEASE:  por_n  <= 1'b1;
            ACT_CRST_ASSERT:  crst_n <= 1'b0;
            ACT_CRST_RELEASE: crst_n <= 1'b1;
            ACT_BOOT64_SET:   boot64 <= 1'b1;
            ACT_DBG_SET:      dbg    <= 1'b1;
            ACT_DBG_CLEAR:    dbg    <= 1'b0;
            default: ;
         endcase
      end
   end

   generate
      if (NO_CLAMP) begin : g_no_clamp
         assign clamp = 1'b0;
      end else begin : g_clamp
         logic clamp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               clamp_q <= !LIVE;
            else if (act_en && act_kind == ACT_CLAMP_SET)
               clamp_q <= 1'b1;
            else if (act_en && act_kind == ACT_CLAMP_RELEASE)
               clamp_q <= 1'b0;
         end
         assign clamp = clamp_q;

         // R4: clamp opens while the power-on reset still holds
         p_clamp_rel_under_por_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(clamp) |-> !por_n);
         // R7: clamp closes only after the debug flag is gone
         p_clamp_set_no_dbg_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(clamp) |-> !dbg);
      end
   endgenerate

   // R4: power-on reset lifts only on a fully powered, unclamped core
   p_por_rel_powered_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(por_n) |-> ((sw == '0) && !clamp));
   // R4: core reset lifts after the power-on reset
   p_crst_after_por_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crst_n) |-> por_n);
   // R4: debug flag comes last
   p_dbg_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg) |-> (crst_n && por_n));
   // R5: ramp steps only ever close further switches
   p_ramp_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sw) && (sw != '1)) |-> ((sw & ~$past(sw)) == '0));
   // R7: switches open only with reset held and debug flag clear
   p_off_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sw) && (sw == '1)) |-> (!por_n && !dbg));

endmodule

// File: rtl/cps_sequencer.sv
module cps_sequencer
   import cps_pkg::*;
#(
   parameter int N          = 8,
   parameter int IDX_W      = 3,
   parameter int SW_W       = 8,
   parameter int DLY_W      = 8,
   parameter int SETTLE_CYC = 250,
   parameter int CNT_W      = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  cps_op_e           cmd_op,
   input  logic [IDX_W-1:0]  cmd_tgt,
   input  logic [IDX_W-1:0]  cmd_req,
   input  logic [DLY_W-1:0]  step_delay,
   input  logic [N*SW_W-1:0] cur_sw_all,
   input  logic              tmr_expire,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output logic              busy,
   output logic              done,
   output logic              act_en,
   output cps_act_e          act_kind,
   output logic [SW_W-1:0]   act_sw,
   output logic [IDX_W-1:0]  act_core
);

   localparam int RAMP_N   = SW_W / 2 + 1;
   localparam int ON_LAST  = 3 + RAMP_N + 3;
   localparam int STEP_W   = $clog2(ON_LAST + 1);
   localparam logic [STEP_W-1:0] S_CRST   = STEP_W'(0);
   localparam logic [STEP_W-1:0] S_POR    = STEP_W'(1);
   localparam logic [STEP_W-1:0] S_BOOT   = STEP_W'(2);
   localparam logic [STEP_W-1:0] S_RAMP0  = STEP_W'(3);
   localparam logic [STEP_W-1:0] S_RAMPZ  = STEP_W'(3 + RAMP_N - 1);
   localparam logic [STEP_W-1:0] S_CLREL  = STEP_W'(3 + RAMP_N);
   localparam logic [STEP_W-1:0] S_PORREL = STEP_W'(3 + RAMP_N + 1);
   localparam logic [STEP_W-1:0] S_CRREL  = STEP_W'(3 + RAMP_N + 2);
   localparam logic [STEP_W-1:0] S_DBG    = STEP_W'(ON_LAST);
   localparam logic [STEP_W-1:0] S_OFFSW  = STEP_W'(3);

   logic              busy_q, done_q, on_q, all_q;
   logic [IDX_W-1:0]  tgt_q, req_q;
   logic [STEP_W-1:0] step_q, nxt_step;
   logic              last, long_gap, fire, accept, more;
   logic [SW_W-1:0]   cur_sw;
   logic [CNT_W-1:0]  dly_eff;
   logic [IDX_W:0]    nt1, nt;

   function automatic logic [SW_W-1:0] ramp_val(input logic [STEP_W-1:0] s);
      int k;
      k = 2 * int'(s) + 1;
      return (k >= SW_W) ? '0 : ({SW_W{1'b1}} << k);
   endfunction

   assign cur_sw  = cur_sw_all[32'(tgt_q) * SW_W +: SW_W];
   assign dly_eff = (step_delay == '0) ? CNT_W'(1) : CNT_W'(step_delay);
   assign fire    = busy_q && tmr_expire;
   assign accept  = !busy_q && cmd_valid;

   assign nt1  = {1'b0, tgt_q} + (IDX_W+1)'(1);
   assign nt   = (nt1 == {1'b0, req_q}) ? nt1 + (IDX_W+1)'(1) : nt1;
   assign more = all_q && (nt < (IDX_W+1)'(N));

   always_comb begin
      act_kind = ACT_DBG_CLEAR;
      act_sw   = '1;
      nxt_step = step_q + STEP_W'(1);
      last     = 1'b0;
      long_gap = 1'b0;
      if (on_q) begin
         if (step_q == S_CRST)
            act_kind = ACT_CRST_ASSERT;
         else if (step_q == S_POR)
            act_kind = ACT_POR_ASSERT;
         else if (step_q == S_BOOT)
            act_kind = ACT_BOOT64_SET;
         else if (step_q == S_RAMP0 && cur_sw == '0) begin
            act_kind = ACT_CLAMP_RELEASE;
            nxt_step = S_PORREL;
         end else if (step_q >= S_RAMP0 && step_q <= S_RAMPZ) begin
            act_kind = ACT_SW_WRITE;
            act_sw   = ramp_val(step_q - S_RAMP0);
            long_gap = (step_q == S_RAMPZ);
         end else if (step_q == S_CLREL)
            act_kind = ACT_CLAMP_RELEASE;
         else if (step_q == S_PORREL)
            act_kind = ACT_POR_RELEASE;
         else if (step_q == S_CRREL)
            act_kind = ACT_CRST_RELEASE;
         else begin
            act_kind = ACT_DBG_SET;
            last     = (step_q == S_DBG);
         end
      end else begin
         case (step_q)
            STEP_W'(0): act_kind = ACT_DBG_CLEAR;
            STEP_W'(1): act_kind = ACT_CLAMP_SET;
            STEP_W'(2): act_kind = ACT_POR_ASSERT;
            default: begin
               act_kind = ACT_SW_WRITE;
               act_sw   = '1;
               last     = (step_q == S_OFFSW);
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         on_q   <= 1'b0;
         all_q  <= 1'b0;
         tgt_q  <= '0;
         req_q  <= '0;
         step_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            step_q <= '0;
            case (cmd_op)
               OP_ON: begin
                  busy_q <= 1'b1;
                  on_q   <= 1'b1;
                  all_q  <= 1'b0;
                  tgt_q  <= cmd_tgt;
               end
               OP_OFF: begin
                  busy_q <= 1'b1;
                  on_q   <= 1'b0;
                  all_q  <= 1'b0;
                  tgt_q  <= cmd_tgt;
               end
               OP_OFF_OTHERS: begin
                  busy_q <= 1'b1;
                  on_q   <= 1'b0;
                  all_q  <= 1'b1;
                  req_q  <= cmd_req;
                  tgt_q  <= (cmd_req == '0) ? IDX_W'(1) : '0;
               end
               default: done_q <= 1'b1;
            endcase
         end else if (fire) begin
            if (last && more) begin
               tgt_q  <= nt[IDX_W-1:0];
               step_q <= '0;
            end else if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else
               step_q <= nxt_step;
         end
      end
   end

   assign tmr_load  = (accept && cmd_op != OP_NOP) || (fire && !(last && !more));
   assign tmr_val   = (fire && long_gap) ? dly_eff + CNT_W'(SETTLE_CYC) : dly_eff;
   assign cmd_ready = !busy_q;
   assign busy      = busy_q;
   assign done      = done_q;
   assign act_en    = fire;
   assign act_core  = tgt_q;

   // R2: completion pulse only when idle
   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R2: a running sequence always ends with done
   p_busy_fall_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R3: the step timer never fires outside a sequence
   p_expire_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_expire |-> busy_q);

endmodule

// File: rtl/cpu_core_pwr_seq.sv
module cpu_core_pwr_seq
   import cps_pkg::*;
#(
   parameter int CLUSTERS     = 2,
   parameter int CORES_PER_CL = 4,
   parameter int SW_W         = 8,
   parameter int DLY_W        = 8,
   parameter int SETTLE_CYC   = 250,
   parameter int BOOT_CORE    = 0,
   localparam int N           = CLUSTERS * CORES_PER_CL,
   localparam int CL_W        = $clog2(CLUSTERS),
   localparam int CO_W        = $clog2(CORES_PER_CL),
   localparam int IDX_W       = CL_W + CO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [CL_W-1:0]   cmd_cluster,
   input  logic [CO_W-1:0]   cmd_core,
   input  logic [IDX_W-1:0]  cmd_req_id,
   input  logic [DLY_W-1:0]  step_delay,
   output logic              busy,
   output logic              done,
   output logic [N*SW_W-1:0] pwr_sw,
   output logic [N-1:0]      out_clamp,
   output logic [N-1:0]      por_rst_n,
   output logic [N-1:0]      core_rst_n,
   output logic [N-1:0]      boot64,
   output logic [N-1:0]      dbg_pwrup
);

   localparam int SETTLE_W = $clog2(SETTLE_CYC + 1);
   localparam int CNT_W    = ((DLY_W > SETTLE_W) ? DLY_W : SETTLE_W) + 1;

   generate
      if (CLUSTERS < 2 || (CLUSTERS & (CLUSTERS - 1)) != 0) begin : g_bad_clusters
         $error("CLUSTERS must be a power of two of at least 2");
      end
      if (CORES_PER_CL < 2 || (CORES_PER_CL & (CORES_PER_CL - 1)) != 0) begin : g_bad_cores
         $error("CORES_PER_CL must be a power of two of at least 2");
      end
      if (SW_W < 2 || (SW_W % 2) != 0) begin : g_bad_sw
         $error("SW_W must be even and at least 2");
      end
      if (BOOT_CORE < 0 || BOOT_CORE >= N) begin : g_bad_boot
         $error("BOOT_CORE out of range");
      end
      if (DLY_W < 1 || SETTLE_CYC < 0) begin : g_bad_dly
         $error("DLY_W must be positive and SETTLE_CYC non-negative");
      end
   endgenerate

   logic             tmr_load, tmr_expire;
   logic [CNT_W-1:0] tmr_val;
   logic             act_en;
   cps_act_e         act_kind;
   logic [SW_W-1:0]  act_sw;
   logic [IDX_W-1:0] act_core;

   cps_step_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_expire)
   );

   cps_sequencer #(
      .N          (N),
      .IDX_W      (IDX_W),
      .SW_W       (SW_W),
      .DLY_W      (DLY_W),
      .SETTLE_CYC (SETTLE_CYC),
      .CNT_W      (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_op     (cps_op_e'(cmd_op)),
      .cmd_tgt    ({cmd_cluster, cmd_core}),
      .cmd_req    (cmd_req_id),
      .step_delay (step_delay),
      .cur_sw_all (pwr_sw),
      .tmr_expire (tmr_expire),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .busy       (busy),
      .done       (done),
      .act_en     (act_en),
      .act_kind   (act_kind),
      .act_sw     (act_sw),
      .act_core   (act_core)
   );

   generate
      for (genvar i = 0; i < N; i++) begin : g_core
         logic sel;
         assign sel = act_en && (act_core == IDX_W'(i));
         cps_core_bank #(
            .SW_W     (SW_W),
            .IS_BOOT  (i == BOOT_CORE),
            .NO_CLAMP (i == 0)
         ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_en   (sel),
            .act_kind (act_kind),
            .act_sw   (act_sw),
            .sw       (pwr_sw[i*SW_W +: SW_W]),
            .clamp    (out_clamp[i]),
            .por_n    (por_rst_n[i]),
            .crst_n   (core_rst_n[i]),
            .boot64   (boot64[i]),
            .dbg      (dbg_pwrup[i])
         );
      end
   endgenerate

   // R8: core 0 output clamp stays open
   p_core0_unclamped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_clamp[0]);
   // R2: no step lands while the port is free to take a command
   p_no_step_when_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |=> $stable(pwr_sw) || $past(busy));

endmodule

// File: tb/cpu_core_pwr_seq_tb.sv
module cpu_core_pwr_seq_tb;

   localparam int NCL = 2, NCO = 4, N = 8, SWW = 8, DW = 8, SETTLE = 20;
   localparam int F_SW = 0, F_CL = 1, F_POR = 2, F_CRST = 3, F_BOOT = 4, F_DBG = 5, F_NONE = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [1:0]    cmd_op = 2'b00;
   logic [0:0]    cmd_cluster = '0;
   logic [1:0]    cmd_core = '0;
   logic [2:0]    cmd_req_id = '0;
   logic [DW-1:0] step_delay = '0;
   logic          busy, done;
   logic [N*SWW-1:0] pwr_sw;
   logic [N-1:0]  out_clamp, por_rst_n, core_rst_n, boot64, dbg_pwrup;

   always #2 clk = ~clk;

   cpu_core_pwr_seq #(
      .CLUSTERS(NCL), .CORES_PER_CL(NCO), .SW_W(SWW), .DLY_W(DW),
      .SETTLE_CYC(SETTLE), .BOOT_CORE(0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_cluster(cmd_cluster), .cmd_core(cmd_core),
      .cmd_req_id(cmd_req_id), .step_delay(step_delay), .busy(busy), .done(done),
      .pwr_sw(pwr_sw), .out_clamp(out_clamp), .por_rst_n(por_rst_n),
      .core_rst_n(core_rst_n), .boot64(boot64), .dbg_pwrup(dbg_pwrup)
   );

   typedef struct {
      int         due;
      int         core;
      logic [7:0] sw;
      logic       cl, por, crst, boot, dbg, dn, bsy;
      string      tag;
   } item_t;

   item_t      q[$];
   int         cyc = 0;
   int         n_chk = 0;
   int         n_bad = 0;
   int         t_cur;
   logic [7:0] m_sw [N];
   logic       m_cl [N], m_por [N], m_crst [N], m_boot [N], m_dbg [N];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check_item(input item_t it);
      logic [14:0] act, exp;
      act = {pwr_sw[it.core*8 +: 8], out_clamp[it.core], por_rst_n[it.core],
             core_rst_n[it.core], boot64[it.core], dbg_pwrup[it.core], done, busy};
      exp = {it.sw, it.cl, it.por, it.crst, it.boot, it.dbg, it.dn, it.bsy};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s core %0d cycle %0d: actual %h expected %h (sw,clamp,por_n,crst_n,boot64,dbg,done,busy)",
                  it.tag, it.core, it.due, act, exp);
      end
   endtask

   // monitor: compare queued expectations after their due edge
   always @(negedge clk) begin
      if (rst_n) begin
         while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            if (it.due < cyc) begin
               n_chk++;
               n_bad++;
               $display("FAIL %s: item due %0d missed, actual cycle %0d expected cycle %0d",
                        it.tag, it.due, cyc, it.due);
            end else
               check_item(it);
         end
      end
   end

   function automatic item_t snap(int due, int c, bit dn, bit bsy, string tag);
      item_t it;
      it.due = due; it.core = c; it.sw = m_sw[c]; it.cl = m_cl[c];
      it.por = m_por[c]; it.crst = m_crst[c]; it.boot = m_boot[c];
      it.dbg = m_dbg[c]; it.dn = dn; it.bsy = bsy; it.tag = tag;
      return it;
   endfunction

   function automatic void slot(int c, int gap, int fld, logic [7:0] v, bit fin, string tag);
      t_cur += gap;
      q.push_back(snap(t_cur - 1, c, 1'b0, 1'b1, "R3 state unchanged before step"));
      case (fld)
         F_SW:   m_sw[c]   = v;
         F_CL:   m_cl[c]   = v[0];
         F_POR:  m_por[c]  = v[0];
         F_CRST: m_crst[c] = v[0];
         F_BOOT: m_boot[c] = v[0];
         F_DBG:  m_dbg[c]  = v[0];
         default: ;
      endcase
      q.push_back(snap(t_cur, c, fin, !fin, tag));
      if (fin) q.push_back(snap(t_cur + 1, c, 1'b0, 1'b0, "R2 done is one cycle"));
   endfunction

   function automatic void plan_on(int c, int d);
      slot(c, d, F_CRST, 8'd0, 1'b0, "R4 core reset asserted");
      slot(c, d, F_POR,  8'd0, 1'b0, "R4 power-on reset asserted");
      slot(c, d, F_BOOT, 8'd1, 1'b0, "R4 boot64 set");
      if (m_sw[c] == 8'h00)
         slot(c, d, F_CL, 8'd0, 1'b0, "R6 ramp skipped, clamp released");
      else begin
         for (int s = 0; s < 5; s++) begin
            logic [15:0] w;
            w = 16'h00FF << (2 * s + 1);
            slot(c, d, F_SW, w[7:0], 1'b0, "R5 ramp step");
         end
         slot(c, d + SETTLE, F_CL, 8'd0, 1'b0,
              (c == 0) ? "R8 core 0 clamp stays open" : "R5 settle then clamp release");
      end
      slot(c, d, F_POR,  8'd1, 1'b0, "R4 power-on reset released");
      slot(c, d, F_CRST, 8'd1, 1'b0, "R4 core reset released");
      slot(c, d, F_DBG,  8'd1, 1'b1, "R4 debug flag last");
   endfunction

   function automatic void plan_off(int c, int d, bit fin, string tag);
      slot(c, d, F_DBG, 8'd0, 1'b0, tag);
      if (c == 0) slot(c, d, F_NONE, 8'd0, 1'b0, "R8 core 0 not clamped");
      else        slot(c, d, F_CL,   8'd1, 1'b0, "R7 clamp engaged");
      slot(c, d, F_POR, 8'd0, 1'b0, "R7 power-on reset asserted");
      slot(c, d, F_SW, 8'hFF, fin, "R7 switch opened last");
   endfunction

   task automatic run_cmd(input logic [1:0] op, input int tgt, input int req,
                          input int dly, input bit hold);
      int d;
      d = (dly == 0) ? 1 : dly;
      @(negedge clk);
      t_cur = cyc + 1;
      case (op)
         2'b01: plan_on(tgt, d);
         2'b10: plan_off(tgt, d, 1'b1, "R7 debug flag cleared first");
         2'b11: begin
            int lastc;
            lastc = (req == N - 1) ? N - 2 : N - 1;
            for (int c = 0; c < N; c++)
               if (c != req) plan_off(c, d, c == lastc, "R9 next core in ascending order");
            q.push_back(snap(t_cur + 1, req, 1'b0, 1'b0, "R9 requester untouched"));
         end
         default: begin
            q.push_back(snap(t_cur, tgt, 1'b1, 1'b0, "R10 no-op done on accept"));
            q.push_back(snap(t_cur + 1, tgt, 1'b0, 1'b0, "R10 no-op changes nothing"));
            t_cur = t_cur;
         end
      endcase
      cmd_op      = op;
      cmd_cluster = 1'(tgt / NCO);
      cmd_core    = 2'(tgt % NCO);
      cmd_req_id  = 3'(req);
      step_delay  = DW'(dly);
      cmd_valid   = 1'b1;
      @(negedge clk);
      if (hold) begin
         // R2: a different command held valid while busy must be ignored
         cmd_op = 2'b10;
         repeat (3) @(negedge clk);
      end
      cmd_valid = 1'b0;
      while (cyc < t_cur + 2) @(negedge clk);
   endtask

   initial begin
      #800000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < N; c++) begin
         m_sw[c] = (c == 0) ? 8'h00 : 8'hFF;
         m_cl[c] = 1'b0;
         if (c != 0) m_cl[c] = 1'b1;
         m_por[c] = (c == 0); m_crst[c] = (c == 0);
         m_boot[c] = (c == 0); m_dbg[c] = (c == 0);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int c = 0; c < N; c++)
         check_item(snap(cyc, c, 1'b0, 1'b0, "R1 reset state"));

      run_cmd(2'b01, 5, 0, 3, 1'b0);   // full power-on of cluster 1 core 1
      run_cmd(2'b10, 5, 0, 2, 1'b0);   // power-off of the same core
      run_cmd(2'b01, 0, 0, 1, 1'b0);   // boot core already on: ramp skipped
      run_cmd(2'b10, 0, 0, 2, 1'b0);   // core 0 off, never clamped
      run_cmd(2'b01, 0, 0, 1, 1'b0);   // core 0 on with full ramp
      run_cmd(2'b01, 2, 0, 0, 1'b1);   // delay 0 acts as 1, extra valid ignored
      run_cmd(2'b11, 0, 2, 1, 1'b0);   // off all others, requester 2
      run_cmd(2'b00, 2, 0, 4, 1'b0);   // no-op
      run_cmd(2'b11, 0, 0, 2, 1'b0);   // off all others, requester 0

      repeat (2) @(negedge clk);
      if (q.size() != 0) begin
         n_chk++;
         n_bad++;
         $display("FAIL R2 pending expectations: actual %0d expected 0", q.size());
      end
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule